// File: doc/BRIEF.md
# ADC Conversion Accumulation Sequencer

This block drives a successive-approximation converter and sums a programmable group of its 12-bit samples into a 16-bit result. An 8-bit configuration register holds three fields: a SAR clock divisor, a group-size code and a gain flag. The block derives a SAR clock enable from the source clock. Each conversion takes a fixed number of those enables. The block then samples the converter output and adds it to the running sum.

There are two start modes. In normal mode, every conversion in the group waits for its own start request. In burst mode, one start request runs the whole group back to back. The end-of-conversion pulse and the window-compare strobe fire only when the last conversion of the group finishes. The result register loads in that same cycle. Threshold comparison, gain and the analog front end lie outside the block.

Top module: `adc_accum_seq`

## Requirements
- R1: After reset, `cfg_rdata` reads 0xF8, `result` is 0, and `busy`, `eoc_irq` and `win_strobe` are low.
- R2: Field layout of the configuration register:
  - Bits 7:3 are the divisor D.
  - Bits 2:1 are the group code.
  - Bit 0 is the gain flag, which is stored and read back.

  `sar_tick` is high for one cycle in every D+1 source cycles.
- R3: Group code 00 runs 1 conversion, 01 runs 4, 10 runs 8 and 11 runs 16. `result` is the sum of the group's samples.
- R4: `eoc_irq` and `win_strobe` pulse high together, for exactly one cycle, only when the last conversion of a group completes. `result` changes only in that cycle.
- R5: With `burst_en` low, each conversion needs its own `start`. Between conversions the block waits idle with `busy` low.
- R6: With `burst_en` high, a single `start` runs every conversion of the group without further requests.
- R7: A `start` that arrives while `busy` is high is ignored. It neither restarts nor extends the group.
- R8: When the group code is 00 and `left_just` is high, `result` is the sample shifted left by 4 bits. For any other group code, `left_just` is ignored and the result is right-justified.
- R9: Each conversion lasts 12 SAR clock enables. With D=0, `eoc_irq` of a single-conversion group is high 12 cycles after the edge that accepts `start`.
- R10: The sum restarts at the first conversion of each group, so a group's result never includes samples from an earlier group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration register contents |
| burst_en | input | 1 | Burst mode select, latched at group start |
| left_just | input | 1 | Left-justify request for single-conversion groups |
| start | input | 1 | Conversion start request |
| conv_req | output | 1 | One-cycle pulse telling the converter model a conversion begins |
| conv_data | input | 12 | Sample from the converter model |
| sar_tick | output | 1 | Divided SAR clock enable |
| busy | output | 1 | A conversion is in progress |
| result | output | 16 | Accumulated group result |
| eoc_irq | output | 1 | End-of-group pulse |
| win_strobe | output | 1 | Window-compare strobe, issued with the end-of-group pulse |

## Verification
The bench checks that the end-of-group pulse comes once per group, not once per conversion. A design that pulsed after each sample would show a count of four or more where one is expected.

It sends a second `start` in the middle of a burst. A design that restarted the group on that request would give a longer latency and a wrong sum.

It asks for left justification together with a multi-conversion group. A design that obeyed the request would shift a 16-bit sum out of range.

It runs groups back to back with different samples. This exposes an accumulator that is not cleared at the start of a group. The exact 12-cycle and 192-cycle latencies at divisor 0 catch an off-by-one in the tick count.

// File: rtl/adc_accum_seq.sv
module adc_accum_seq #(
  parameter int DATA_W     = 12,
  parameter int RES_W      = 16,
  parameter int CONV_TICKS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              burst_en,
  input  logic              left_just,
  input  logic              start,
  output logic              conv_req,
  input  logic [DATA_W-1:0] conv_data,
  output logic              sar_tick,
  output logic              busy,
  output logic [RES_W-1:0]  result,
  output logic              eoc_irq,
  output logic              win_strobe
);
  localparam int TW = $clog2(CONV_TICKS);
  localparam int PAD = RES_W - DATA_W;

  logic [7:0]       cfg;
  logic [4:0]       div_cnt;
  logic [TW-1:0]    tick_cnt;
  logic [3:0]       idx, grp_last, n_last;
  logic             burst_q;
  logic [RES_W-1:0] acc, sum_next;

  wire [4:0] div  = cfg[7:3];
  wire [1:0] rpt  = cfg[2:1];
  wire       last_tick = sar_tick && (tick_cnt == TW'(CONV_TICKS - 1));

  assign cfg_rdata = cfg;
  assign sar_tick  = (div_cnt == div);
  assign sum_next  = (idx == 4'd0 ? '0 : acc) + {{PAD{1'b0}}, conv_data};

  always_comb
    case (rpt)
      2'b00:   n_last = 4'd0;
      2'b01:   n_last = 4'd3;
      2'b10:   n_last = 4'd7;
      default: n_last = 4'd15;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg     <= 8'hF8;
      div_cnt <= '0;
    end else begin
      if (cfg_we) cfg <= cfg_wdata;
      if (cfg_we || sar_tick) div_cnt <= '0;
      else                    div_cnt <= div_cnt + 5'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy       <= 1'b0;
      tick_cnt   <= '0;
      idx        <= '0;
      grp_last   <= '0;
      burst_q    <= 1'b0;
      acc        <= '0;
      result     <= '0;
      conv_req   <= 1'b0;
      eoc_irq    <= 1'b0;
      win_strobe <= 1'b0;
    end else begin
      conv_req   <= 1'b0;
      eoc_irq    <= 1'b0;
      win_strobe <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          tick_cnt <= '0;
          conv_req <= 1'b1;
          if (idx == 4'd0) begin
            grp_last <= n_last;
            burst_q  <= burst_en;
          end
        end
      end else if (last_tick) begin
        acc      <= sum_next;
        tick_cnt <= '0;
        if (idx == grp_last) begin
          idx        <= '0;
          busy       <= 1'b0;
          eoc_irq    <= 1'b1;
          win_strobe <= 1'b1;
          result     <= (grp_last == 4'd0 && left_just) ?
                        {conv_data, {PAD{1'b0}}} : sum_next;
        end else begin
          idx <= idx + 4'd1;
          if (burst_q) conv_req <= 1'b1;
          else         busy     <= 1'b0;
        end
      end else if (sar_tick) begin
        tick_cnt <= tick_cnt + TW'(1);
      end
    end

  assert_eoc_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |=> !eoc_irq);
  assert_eoc_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |-> ($past(busy) && !busy));
  assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_irq |-> $stable(result));
  assert_win_with_eoc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_strobe) |-> eoc_irq);
  assert_req_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> busy);
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sar_tick && !cfg_we && div != 5'd0) |=> !sar_tick);
endmodule

// File: tb/adc_accum_seq_test.sv
module adc_accum_seq_test;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, burst_en = 0, left_just = 0, start = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic [11:0] conv_data = 0;
  logic conv_req, sar_tick, busy, eoc_irq, win_strobe;
  logic [15:0] result;
  int checks = 0, fails = 0, eoc_cnt = 0, win_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_accum_seq uut (.clk, .rst_n, .cfg_we, .cfg_wdata, .cfg_rdata, .burst_en,
    .left_just, .start, .conv_req, .conv_data, .sar_tick, .busy, .result,
    .eoc_irq, .win_strobe);

  always @(negedge clk) begin
    if (eoc_irq) eoc_cnt++;
    if (win_strobe) win_cnt++;
  end

  // {burst, code[1:0], left_just, sample[11:0], expected[15:0]}
  localparam logic [31:0] VEC [8] = '{
    {1'b0, 2'b00, 1'b0, 12'h123, 16'h0123},
    {1'b0, 2'b00, 1'b1, 12'h123, 16'h1230},
    {1'b0, 2'b01, 1'b0, 12'h100, 16'h0400},
    {1'b0, 2'b01, 1'b1, 12'h100, 16'h0400},
    {1'b1, 2'b10, 1'b0, 12'h0AB, 16'h0558},
    {1'b1, 2'b11, 1'b0, 12'hFFF, 16'hFFF0},
    {1'b1, 2'b00, 1'b1, 12'hABC, 16'hABC0},
    {1'b0, 2'b10, 1'b0, 12'h001, 16'h0008}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic tick_gap(output int gap);
    while (!sar_tick) @(negedge clk);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!sar_tick);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int gap, cyc, e0;
    repeat (3) @(negedge clk);
    check("R1 cfg", cfg_rdata, 8'hF8);
    check("R1 result", result, 0);
    check("R1 outputs", {busy, eoc_irq, win_strobe}, 0);
    rst_n = 1;
    @(negedge clk);

    tick_gap(gap); check("R2 gap at reset divisor", gap, 32);
    write_cfg(8'b00011_00_1);
    check("R2 gain readback", cfg_rdata, 8'h19);
    tick_gap(gap); check("R2 gap divisor 3", gap, 4);
    write_cfg(8'h00);
    tick_gap(gap); check("R2 gap divisor 0", gap, 1);

    pulse_start();
    cyc = 1;
    while (!eoc_irq) begin @(negedge clk); cyc++; end
    check("R9 single latency", cyc, 13);

    foreach (VEC[i]) begin
      logic [31:0] v = VEC[i];
      int n = (v[30:29] == 0) ? 1 : (4 << (v[30:29] - 1));
      write_cfg({5'd0, v[30:29], 1'b0});
      burst_en = v[31]; left_just = v[28]; conv_data = v[27:16];
      e0 = eoc_cnt;
      if (v[31]) begin
        pulse_start();
        wait_idle();
      end else
        for (int k = 0; k < n; k++) begin pulse_start(); wait_idle(); end
      @(negedge clk);
      check("R3 R6 R8 R10 vector result", result, v[15:0]);
      check("R4 one eoc per group", eoc_cnt - e0, 1);
    end
    check("R4 strobe count matches", win_cnt, eoc_cnt);

    // R5: without burst, one start gives one conversion and then waits
    write_cfg(8'b00000_01_0);
    burst_en = 0; left_just = 0; conv_data = 12'h010;
    e0 = eoc_cnt;
    pulse_start();
    repeat (40) @(negedge clk);
    check("R5 idle between conversions", busy, 0);
    check("R5 no eoc after partial group", eoc_cnt - e0, 0);
    conv_data = 12'h020;
    for (int k = 0; k < 3; k++) begin pulse_start(); wait_idle(); end
    @(negedge clk);
    check("R5 mixed sample sum", result, 16'h0070);

    // R7 and R6: a second start in mid-burst is ignored
    write_cfg(8'b00000_11_0);
    burst_en = 1; conv_data = 12'h011;
    e0 = eoc_cnt;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    cyc = 1;
    repeat (50) begin @(negedge clk); cyc++; end
    start = 1; @(negedge clk); start = 0; cyc++;
    while (!eoc_irq) begin @(negedge clk); cyc++; end
    check("R7 burst latency unchanged", cyc, 16 * 12 + 1);
    check("R7 burst sum", result, 16 * 'h011);
    repeat (30) @(negedge clk);
    check("R7 no extra group", eoc_cnt - e0, 1);
    check("R7 idle after group", busy, 0);

    // R10: new group does not carry the old sum
    write_cfg(8'b00000_01_0);
    conv_data = 12'h001;
    pulse_start(); wait_idle(); @(negedge clk);
    check("R10 fresh sum", result, 16'h0004);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule